// File: doc/BRIEF.md
# External Multiplexed Memory Bus Controller

This block runs the external memory pins of an 8-bit controller core. Time is split into machine cycles of twelve oscillator clocks. At the start of each machine cycle the controller picks one kind of access from the core's requests: a two-byte code fetch, an external data read, an external data write, a low-power pin state, or nothing. It then plays out a fixed pin schedule for that cycle. The low address byte and the data share one 8-bit bus whose output enable is a separate signal. The high address byte is driven on its own port. The controller produces the address latch strobe, the code-read strobe and the data read and write strobes.

A code fetch reads the byte at the program counter in the first half of the cycle and the byte at the program counter plus one in the second half. Each half is decided on its own, so a fetch that straddles the top of the internal ROM mixes one internal and one external byte. An external byte is returned on `rx_byte` with `code_valid`. A byte that belongs to internal ROM raises `rom_hit` at the same point instead, and that half produces no bus traffic. The strap input `int_rom_en` selects whether internal ROM is used at all.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, addr_latch is 0, code_oe_n, xrd_n and xwr_n are 1, mux_oe is 0, code_valid, rom_hit and data_valid are 0, and hi_port is 0x00.
- R2: A machine cycle lasts 12 clocks, phases 0 to 11. Phase 0 is the clock after the edge that starts the cycle, and the first cycle starts at the first edge after reset is released. The request inputs, pc, dptr, wdata, int_rom_en, idle and pdown are sampled only at that starting edge. A change to any of them during the cycle has no effect on it.
- R3: The access kind is chosen by priority: pdown, then idle, then write, then read, then fetch. With no request, all strobes are inactive, addr_latch is low, mux_oe is 0 and hi_port keeps its previous value.
- R4: A fetch cycle has two halves of 6 phases. Half 0 uses address pc and half 1 uses address pc+1, wrapping modulo 65536. In each half, addr_latch is high in local phases 0 and 1, and hi_port carries the high byte of that half's address.
- R5: In a half served externally, mux_out carries the low address byte with mux_oe=1 in local phases 0 to 2, code_oe_n is low in local phases 3 to 5, and mux_oe is 0 there. mux_in is sampled at the edge that ends local phase 5. That byte appears on rx_byte with code_valid high for one clock, in phase 6 for half 0 and in phase 0 of the next cycle for half 1.
- R6: A half is served internally when int_rom_en=1 and its address is below ROM_BYTES (default 4096). In that half code_oe_n stays high, mux_oe stays 0, and rom_hit pulses at the time code_valid would have pulsed. With int_rom_en=0, every half is external.
- R7: In a data read cycle, addr_latch is high in phases 0 and 1 only, code_oe_n stays high, mux_out carries the low byte of dptr with mux_oe=1 in phases 0 to 2, and xrd_n is low in phases 5 to 10. mux_in is sampled at the edge that ends phase 10 and appears on rx_byte with data_valid high in phase 11.
- R8: In a data write cycle, xwr_n is low in phases 5 to 10 and mux_oe is 1 for the whole cycle. mux_out carries the low byte of dptr in phases 0 to 2 and wdata in phases 3 to 11. addr_latch is high in phases 0 and 1 only.
- R9: In data read and write cycles, hi_port carries the high byte of dptr for the whole cycle.
- R10: In an idle cycle, addr_latch and code_oe_n are both 1 for all 12 phases, xrd_n and xwr_n are 1, and mux_oe is 0. Any pending access request is not served.
- R11: In a power-down cycle, addr_latch and code_oe_n are both 0 for all 12 phases, xrd_n and xwr_n are 1, and mux_oe is 0. Power-down takes priority over idle.
- R12: xrd_n and xwr_n are never low together. code_oe_n is never low while addr_latch is high or while a data strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core requests a two-byte code fetch |
| rd_req | input | 1 | Core requests an external data read |
| wr_req | input | 1 | Core requests an external data write |
| pc | input | 16 | Fetch address of the first code byte |
| dptr | input | 16 | External data address |
| wdata | input | 8 | Byte to write |
| int_rom_en | input | 1 | Strap: 1 lets addresses below ROM_BYTES come from internal ROM |
| idle | input | 1 | Idle pin state request |
| pdown | input | 1 | Power-down pin state request |
| mux_in | input | 8 | Byte read from the shared bus |
| addr_latch | output | 1 | Address latch strobe, active high |
| code_oe_n | output | 1 | External code read strobe, active low |
| xrd_n | output | 1 | External data read strobe, active low |
| xwr_n | output | 1 | External data write strobe, active low |
| mux_out | output | 8 | Low address or write data on the shared bus |
| mux_oe | output | 1 | Shared-bus output enable |
| hi_port | output | 8 | High address byte |
| rx_byte | output | 8 | Last byte captured from the bus |
| code_valid | output | 1 | rx_byte holds an external code byte |
| rom_hit | output | 1 | A fetch half was served by internal ROM |
| data_valid | output | 1 | rx_byte holds external read data |

## Verification
The hardest situation to reach is a fetch whose two halves are served differently. This happens at pc=0x0FFF with internal ROM enabled, and at pc=0xFFFF, where the second address wraps back into internal space. It is made harder by the second byte's valid pulse landing in the first phase of the following machine cycle. The stimulus sweeps the program counter across these boundaries, with the strap both ways, and chains each fetch directly into another cycle kind so that the carried-over pulse is checked against whatever comes next. Requests are also raised and dropped in the middle of a cycle, and several are raised together at a cycle boundary, to show that only the boundary sample and the priority order count.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int MC_LEN   = 12;
  localparam int HALF_LEN = MC_LEN / 2;
  localparam int PH_W     = $clog2(MC_LEN);
  localparam int ADDR_W   = 16;
  localparam int BYTE_W   = 8;

  typedef logic [PH_W-1:0]   ph_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    K_NONE, K_FETCH, K_DRD, K_DWR, K_IDLE, K_PDN
  } kind_t;

  // phase landmarks of the schedule
  localparam ph_t PH_LAST      = ph_t'(MC_LEN - 1);
  localparam ph_t PH_HALF      = ph_t'(HALF_LEN);
  localparam ph_t LOC_ALE_LAST = ph_t'(1);
  localparam ph_t LOC_ADR_LAST = ph_t'(2);
  localparam ph_t LOC_CS_FIRST = ph_t'(3);
  localparam ph_t LOC_CS_LAST  = ph_t'(HALF_LEN - 1);
  localparam ph_t XS_FIRST     = ph_t'(5);
  localparam ph_t XS_LAST      = ph_t'(MC_LEN - 2);

  function automatic ph_t step_phase(ph_t p);
    return (p == PH_LAST) ? '0 : p + ph_t'(1);
  endfunction

  function automatic logic second_half(ph_t p);
    return p >= PH_HALF;
  endfunction

  function automatic ph_t local_phase(ph_t p);
    return (p >= PH_HALF) ? p - PH_HALF : p;
  endfunction

  function automatic logic in_win(ph_t p, ph_t lo, ph_t hi);
    return (p >= lo) && (p <= hi);
  endfunction

  function automatic addr_t half_addr(addr_t base, logic h);
    return base + addr_t'(h);
  endfunction

  function automatic logic code_is_ext(logic rom_en, addr_t a, int unsigned rom_bytes);
    return !rom_en || (32'(a) >= rom_bytes);
  endfunction

  function automatic kind_t pick_kind(logic pdn, logic idl, logic wr, logic rd, logic fe);
    if (pdn)      return K_PDN;
    else if (idl) return K_IDLE;
    else if (wr)  return K_DWR;
    else if (rd)  return K_DRD;
    else if (fe)  return K_FETCH;
    else          return K_NONE;
  endfunction
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fetch_req,
  input  logic  rd_req,
  input  logic  wr_req,
  input  logic  idle,
  input  logic  pdown,
  input  addr_t pc_i,
  input  addr_t dptr_i,
  input  byte_t wdata_i,
  input  logic  rom_en_i,
  output logic  boundary,
  output ph_t   ph_q,
  output ph_t   ph_n,
  output kind_t kind_q,
  output kind_t kind_n,
  output addr_t pc_q,
  output addr_t pc_n,
  output logic  rom_en_q,
  output logic  rom_en_n,
  output addr_t dptr_n,
  output byte_t wdata_n
);
  addr_t dptr_q;
  byte_t wdata_q;

  always_comb begin
    boundary = (ph_q == PH_LAST);
    ph_n     = step_phase(ph_q);
    kind_n   = boundary ? pick_kind(pdown, idle, wr_req, rd_req, fetch_req) : kind_q;
    pc_n     = boundary ? pc_i     : pc_q;
    dptr_n   = boundary ? dptr_i   : dptr_q;
    wdata_n  = boundary ? wdata_i  : wdata_q;
    rom_en_n = boundary ? rom_en_i : rom_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_LAST;
      kind_q   <= K_NONE;
      pc_q     <= '0;
      dptr_q   <= '0;
      wdata_q  <= '0;
      rom_en_q <= 1'b0;
    end else begin
      ph_q     <= ph_n;
      kind_q   <= kind_n;
      pc_q     <= pc_n;
      dptr_q   <= dptr_n;
      wdata_q  <= wdata_n;
      rom_en_q <= rom_en_n;
    end
  end
endmodule

// File: rtl/xbus_strobes.sv
module xbus_strobes
  import xbus_pkg::*;
#(
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ph_t   ph_n,
  input  kind_t kind_n,
  input  addr_t pc_n,
  input  logic  rom_en_n,
  output logic  addr_latch,
  output logic  code_oe_n,
  output logic  xrd_n,
  output logic  xwr_n
);
  ph_t   loc;
  logic  half;
  addr_t faddr;
  logic  fext;
  logic  ale_d, cs_d, rd_d, wr_d;

  always_comb begin
    half  = second_half(ph_n);
    loc   = local_phase(ph_n);
    faddr = half_addr(pc_n, half);
    fext  = code_is_ext(rom_en_n, faddr, ROM_BYTES);
    ale_d = 1'b0;
    cs_d  = 1'b1;
    rd_d  = 1'b1;
    wr_d  = 1'b1;
    case (kind_n)
      K_FETCH: begin
        ale_d = (loc <= LOC_ALE_LAST);
        cs_d  = !(fext && in_win(loc, LOC_CS_FIRST, LOC_CS_LAST));
      end
      K_DRD: begin
        ale_d = (ph_n <= LOC_ALE_LAST);
        rd_d  = !in_win(ph_n, XS_FIRST, XS_LAST);
      end
      K_DWR: begin
        ale_d = (ph_n <= LOC_ALE_LAST);
        wr_d  = !in_win(ph_n, XS_FIRST, XS_LAST);
      end
      K_IDLE: begin
        ale_d = 1'b1;
        cs_d  = 1'b1;
      end
      K_PDN: begin
        ale_d = 1'b0;
        cs_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_latch <= 1'b0;
      code_oe_n  <= 1'b1;
      xrd_n      <= 1'b1;
      xwr_n      <= 1'b1;
    end else begin
      addr_latch <= ale_d;
      code_oe_n  <= cs_d;
      xrd_n      <= rd_d;
      xwr_n      <= wr_d;
    end
  end
endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ph_t   ph_n,
  input  kind_t kind_n,
  input  addr_t pc_n,
  input  logic  rom_en_n,
  input  addr_t dptr_n,
  input  byte_t wdata_n,
  input  ph_t   ph_q,
  input  kind_t kind_q,
  input  addr_t pc_q,
  input  logic  rom_en_q,
  input  byte_t mux_in,
  output byte_t mux_out,
  output logic  mux_oe,
  output byte_t hi_port,
  output byte_t rx_byte,
  output logic  code_valid,
  output logic  rom_hit,
  output logic  data_valid,
  output logic  fetch_cap,
  output logic  rd_cap
);
  // next-phase bus drive
  ph_t   loc_n;
  addr_t faddr_n;
  logic  fext_n;
  logic  oe_d;
  byte_t out_d, hi_d;

  always_comb begin
    loc_n   = local_phase(ph_n);
    faddr_n = half_addr(pc_n, second_half(ph_n));
    fext_n  = code_is_ext(rom_en_n, faddr_n, ROM_BYTES);
    oe_d    = 1'b0;
    out_d   = mux_out;
    hi_d    = hi_port;
    case (kind_n)
      K_FETCH: begin
        oe_d  = fext_n && (loc_n <= LOC_ADR_LAST);
        out_d = faddr_n[BYTE_W-1:0];
        hi_d  = faddr_n[ADDR_W-1:BYTE_W];
      end
      K_DRD: begin
        oe_d  = (ph_n <= LOC_ADR_LAST);
        out_d = dptr_n[BYTE_W-1:0];
        hi_d  = dptr_n[ADDR_W-1:BYTE_W];
      end
      K_DWR: begin
        oe_d  = 1'b1;
        out_d = (ph_n <= LOC_ADR_LAST) ? dptr_n[BYTE_W-1:0] : wdata_n;
        hi_d  = dptr_n[ADDR_W-1:BYTE_W];
      end
      default: ;
    endcase
  end

  // current-phase capture events
  logic fext_q;

  always_comb begin
    fext_q    = code_is_ext(rom_en_q, half_addr(pc_q, second_half(ph_q)), ROM_BYTES);
    fetch_cap = (kind_q == K_FETCH) && (local_phase(ph_q) == LOC_CS_LAST);
    rd_cap    = (kind_q == K_DRD) && (ph_q == XS_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_out    <= '0;
      mux_oe     <= 1'b0;
      hi_port    <= '0;
      rx_byte    <= '0;
      code_valid <= 1'b0;
      rom_hit    <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      mux_out    <= out_d;
      mux_oe     <= oe_d;
      hi_port    <= hi_d;
      code_valid <= fetch_cap && fext_q;
      rom_hit    <= fetch_cap && !fext_q;
      data_valid <= rd_cap;
      if ((fetch_cap && fext_q) || rd_cap)
        rx_byte <= mux_in;
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_req,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [15:0] pc,
  input  logic [15:0] dptr,
  input  logic [7:0]  wdata,
  input  logic        int_rom_en,
  input  logic        idle,
  input  logic        pdown,
  input  logic [7:0]  mux_in,
  output logic        addr_latch,
  output logic        code_oe_n,
  output logic        xrd_n,
  output logic        xwr_n,
  output logic [7:0]  mux_out,
  output logic        mux_oe,
  output logic [7:0]  hi_port,
  output logic [7:0]  rx_byte,
  output logic        code_valid,
  output logic        rom_hit,
  output logic        data_valid
);
  logic  boundary;
  ph_t   ph_q, ph_n;
  kind_t kind_q, kind_n;
  addr_t pc_q, pc_n, dptr_n;
  byte_t wdata_n;
  logic  rom_en_q, rom_en_n;
  logic  fetch_cap, rd_cap;

  xbus_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .rd_req(rd_req), .wr_req(wr_req),
    .idle(idle), .pdown(pdown),
    .pc_i(pc), .dptr_i(dptr), .wdata_i(wdata), .rom_en_i(int_rom_en),
    .boundary(boundary),
    .ph_q(ph_q), .ph_n(ph_n), .kind_q(kind_q), .kind_n(kind_n),
    .pc_q(pc_q), .pc_n(pc_n), .rom_en_q(rom_en_q), .rom_en_n(rom_en_n),
    .dptr_n(dptr_n), .wdata_n(wdata_n)
  );

  xbus_strobes #(.ROM_BYTES(ROM_BYTES)) u_strb (
    .clk(clk), .rst_n(rst_n),
    .ph_n(ph_n), .kind_n(kind_n), .pc_n(pc_n), .rom_en_n(rom_en_n),
    .addr_latch(addr_latch), .code_oe_n(code_oe_n),
    .xrd_n(xrd_n), .xwr_n(xwr_n)
  );

  xbus_dp #(.ROM_BYTES(ROM_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .ph_n(ph_n), .kind_n(kind_n), .pc_n(pc_n), .rom_en_n(rom_en_n),
    .dptr_n(dptr_n), .wdata_n(wdata_n),
    .ph_q(ph_q), .kind_q(kind_q), .pc_q(pc_q), .rom_en_q(rom_en_q),
    .mux_in(mux_in),
    .mux_out(mux_out), .mux_oe(mux_oe), .hi_port(hi_port),
    .rx_byte(rx_byte), .code_valid(code_valid), .rom_hit(rom_hit),
    .data_valid(data_valid), .fetch_cap(fetch_cap), .rd_cap(rd_cap)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_latch,
  input logic code_oe_n,
  input logic xrd_n,
  input logic xwr_n,
  input logic mux_oe,
  input logic code_valid,
  input logic data_valid,
  input logic boundary,
  input logic rd_cap
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xrd_n && !xwr_n));

  // R12
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_oe_n |-> (!addr_latch && xrd_n && xwr_n));

  // R5
  code_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_oe_n |-> !mux_oe);

  // R4
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_latch) |-> $past(addr_latch, 2));

  // R7
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xrd_n) |-> (!$past(xrd_n, 6) && $past(xrd_n, 7)));

  // R8
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xwr_n |-> mux_oe);

  // R5
  code_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> !$past(code_oe_n));

  // R7
  rd_cap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |-> (!xrd_n && !boundary));

  // R7
  data_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !$past(xrd_n));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .addr_latch(addr_latch), .code_oe_n(code_oe_n),
  .xrd_n(xrd_n), .xwr_n(xwr_n), .mux_oe(mux_oe),
  .code_valid(code_valid), .data_valid(data_valid),
  .boundary(boundary), .rd_cap(rd_cap)
);

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [15:0] pc = '0, dptr = '0;
  logic [7:0]  wdata = '0, mux_in = '0;
  logic        int_rom_en = 1'b0, idle = 1'b0, pdown = 1'b0;
  wire         addr_latch, code_oe_n, xrd_n, xwr_n, mux_oe;
  wire         code_valid, rom_hit, data_valid;
  wire  [7:0]  mux_out, hi_port, rx_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit       pend_cv = 1'b0, pend_rh = 1'b0;
  logic [7:0] pend_byte = '0;
  logic [7:0] last_hi = '0;

  always #2.5 clk = ~clk;

  xbus_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .rd_req(rd_req), .wr_req(wr_req),
    .pc(pc), .dptr(dptr), .wdata(wdata), .int_rom_en(int_rom_en),
    .idle(idle), .pdown(pdown), .mux_in(mux_in),
    .addr_latch(addr_latch), .code_oe_n(code_oe_n),
    .xrd_n(xrd_n), .xwr_n(xwr_n), .mux_out(mux_out), .mux_oe(mux_oe),
    .hi_port(hi_port), .rx_byte(rx_byte), .code_valid(code_valid),
    .rom_hit(rom_hit), .data_valid(data_valid)
  );

  task automatic chk(input string tag, input int s, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s phase=%0d actual=%0h expected=%0h", tag, s, got, exp);
    end
  endtask

  // kind codes: 0 none, 1 fetch, 2 read, 3 write, 4 idle, 5 power-down
  task automatic run_mc(input bit f, input bit r, input bit w,
                        input logic [15:0] pcv, input logic [15:0] dpv,
                        input logic [7:0] wdv, input bit rom_en,
                        input bit idl, input bit pdn,
                        input logic [7:0] bA, input logic [7:0] bB,
                        input bit glitch);
    int k;
    logic [15:0] a0, a1;
    bit e0, e1;
    k  = pdn ? 5 : idl ? 4 : w ? 3 : r ? 2 : f ? 1 : 0;
    a0 = pcv;
    a1 = pcv + 16'd1;
    e0 = !rom_en || (a0 >= 16'h1000);
    e1 = !rom_en || (a1 >= 16'h1000);
    fetch_req = f; rd_req = r; wr_req = w;
    pc = pcv; dptr = dpv; wdata = wdv; int_rom_en = rom_en;
    idle = idl; pdown = pdn;
    for (int s = 0; s < 12; s++) begin
      bit h, e;
      int l;
      logic [15:0] a;
      logic ea, ec, er, ew, eo, ecv, erh, edv;
      logic [7:0] eout, ehi;
      @(posedge clk);
      @(negedge clk);
      if (s == 0) begin
        // R2: scramble every sampled input once the cycle has started
        fetch_req = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
        idle = 1'b0; pdown = 1'b0;
        pc = ~pcv; dptr = ~dpv; wdata = ~wdv; int_rom_en = ~rom_en;
      end
      if (glitch && s == 4) begin fetch_req = 1'b1; rd_req = 1'b1; end
      if (glitch && s == 8) begin fetch_req = 1'b0; rd_req = 1'b0; end
      h = (s >= 6);
      l = h ? s - 6 : s;
      a = h ? a1 : a0;
      e = h ? e1 : e0;
      ea = 1'b0; ec = 1'b1; er = 1'b1; ew = 1'b1; eo = 1'b0;
      eout = '0; ehi = last_hi;
      case (k)
        1: begin
          ea = (l < 2); ec = !(e && l >= 3); eo = e && (l < 3);
          eout = a[7:0]; ehi = a[15:8];
        end
        2: begin
          ea = (s < 2); er = !(s >= 5 && s <= 10); eo = (s < 3);
          eout = dpv[7:0]; ehi = dpv[15:8];
        end
        3: begin
          ea = (s < 2); ew = !(s >= 5 && s <= 10); eo = 1'b1;
          eout = (s < 3) ? dpv[7:0] : wdv; ehi = dpv[15:8];
        end
        4: begin ea = 1'b1; ec = 1'b1; end
        5: begin ea = 1'b0; ec = 1'b0; end
        default: ;
      endcase
      ecv = (s == 0) ? pend_cv : (k == 1 && s == 6 && e0);
      erh = (s == 0) ? pend_rh : (k == 1 && s == 6 && !e0);
      edv = (k == 2 && s == 11);
      chk("R4/R10/R11 addr_latch", s, 16'(addr_latch), 16'(ea));
      chk("R5/R6/R11 code_oe_n", s, 16'(code_oe_n), 16'(ec));
      chk("R7 xrd_n", s, 16'(xrd_n), 16'(er));
      chk("R8 xwr_n", s, 16'(xwr_n), 16'(ew));
      chk("R3/R5/R6 mux_oe", s, 16'(mux_oe), 16'(eo));
      if (eo) chk("R5/R8 mux_out", s, 16'(mux_out), 16'(eout));
      chk("R4/R9/R3 hi_port", s, 16'(hi_port), 16'(ehi));
      chk("R5 code_valid", s, 16'(code_valid), 16'(ecv));
      chk("R6 rom_hit", s, 16'(rom_hit), 16'(erh));
      chk("R7 data_valid", s, 16'(data_valid), 16'(edv));
      if (s == 0 && pend_cv) chk("R5 rx_byte half1", s, 16'(rx_byte), 16'(pend_byte));
      if (ecv && s == 6)     chk("R5 rx_byte half0", s, 16'(rx_byte), 16'(bA));
      if (edv)               chk("R7 rx_byte read", s, 16'(rx_byte), 16'(bB));
      mux_in = (s < 5) ? bA : (s == 5) ? bA : bB;
    end
    pend_cv   = (k == 1) && e1;
    pend_rh   = (k == 1) && !e1;
    pend_byte = bB;
    if (k == 1) last_hi = a1[15:8];
    else if (k == 2 || k == 3) last_hi = dpv[15:8];
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pcs [6];
    logic [15:0] dps [4];
    pcs[0] = 16'h0000; pcs[1] = 16'h0FFE; pcs[2] = 16'h0FFF;
    pcs[3] = 16'h1000; pcs[4] = 16'hFFFF; pcs[5] = 16'h7A35;
    dps[0] = 16'h0000; dps[1] = 16'h12FF; dps[2] = 16'hA55A; dps[3] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr_latch", 0, 16'(addr_latch), 16'd0);
    chk("R1 code_oe_n", 0, 16'(code_oe_n), 16'd1);
    chk("R1 xrd_n", 0, 16'(xrd_n), 16'd1);
    chk("R1 xwr_n", 0, 16'(xwr_n), 16'd1);
    chk("R1 mux_oe", 0, 16'(mux_oe), 16'd0);
    chk("R1 hi_port", 0, 16'(hi_port), 16'd0);
    chk("R1 valids", 0, 16'({code_valid, rom_hit, data_valid}), 16'd0);
    rst_n = 1'b1;
    // R3 no request
    run_mc(0,0,0, 16'h0, 16'h0, 8'h0, 0, 0, 0, 8'h11, 8'h22, 0);
    // R4 R5 R6 fetch sweep, strap both ways
    for (int en = 0; en < 2; en++)
      for (int i = 0; i < 6; i++)
        run_mc(1,0,0, pcs[i], 16'h0, 8'h0, en[0], 0, 0,
               8'h30 + 8'(i) + 8'(en*16), 8'hC0 + 8'(i) + 8'(en*16), 0);
    // R7 R9 reads, R8 writes
    for (int i = 0; i < 4; i++)
      run_mc(0,1,0, 16'h0, dps[i], 8'h0, 0, 0, 0, 8'h5A, 8'hA0 + 8'(i), 0);
    for (int i = 0; i < 4; i++)
      run_mc(0,0,1, 16'h0, dps[i], 8'h96 ^ 8'(i), 0, 0, 0, 8'h00, 8'h00, 0);
    // R3 priority: write over read over fetch
    run_mc(1,1,1, 16'h2222, 16'h3344, 8'h77, 0, 0, 0, 8'h01, 8'h02, 0);
    run_mc(1,1,0, 16'h2222, 16'h5566, 8'h00, 0, 0, 0, 8'h03, 8'h4E, 0);
    // R2 mid-cycle requests ignored
    run_mc(0,0,0, 16'h0, 16'h0, 8'h0, 0, 0, 0, 8'h00, 8'h00, 1);
    run_mc(0,0,0, 16'h0, 16'h0, 8'h0, 0, 0, 0, 8'h00, 8'h00, 0);
    // fetch straight into idle, R10
    run_mc(1,0,0, 16'h4000, 16'h0, 8'h0, 0, 0, 0, 8'hE1, 8'hE2, 0);
    run_mc(1,1,1, 16'h4000, 16'h6060, 8'h0, 0, 1, 0, 8'h00, 8'h00, 0);
    // R11 power-down, alone and over idle, then a fetch straight into power-down
    run_mc(1,0,0, 16'h0, 16'h0, 8'h0, 0, 1, 1, 8'h00, 8'h00, 0);
    run_mc(0,0,0, 16'h0, 16'h0, 8'h0, 0, 0, 1, 8'h00, 8'h00, 0);
    run_mc(1,0,0, 16'h8000, 16'h0, 8'h0, 1, 0, 0, 8'h9A, 8'h9B, 0);
    run_mc(0,0,0, 16'h0, 16'h0, 8'h0, 0, 0, 1, 8'h00, 8'h00, 0);
    run_mc(1,0,0, 16'h0FFF, 16'h0, 8'h0, 1, 0, 0, 8'h44, 8'h45, 0);
    run_mc(0,0,0, 16'h0, 16'h0, 8'h0, 0, 0, 0, 8'h00, 8'h00, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule